// File: doc/BRIEF.md
# Two-Plane Grey Display Memory Access Port

This block is the processor-side access logic for a display memory built from two bit planes. Each plane holds a 256 by 256 grid of one-bit pixels. The two planes are combined to give four grey levels. A small register file sets up access to the planes. It holds an access-mode register, horizontal and vertical scroll offsets, a horizontal byte address with a plane-select bit, and a vertical row address. Two data offsets read or write one byte of 8 horizontal pixels at the current address. Every data access then steps the address, either across the row or down the column, as the mode register selects.

A separate pixel-fetch port serves the display side. It takes a coordinate inside the 160 by 152 visible window, adds the scroll offsets modulo 256 on each axis, and returns the 2-bit grey value one cycle later. A mode bit chooses which plane carries the heavier bit of that grey value. Both planes are held inside the block. Panel timing and panel drive lie outside it.

Top module: `lcdp_bitplane_port`

## Requirements
- R1: After reset the mode flags, both scroll offsets, the column address, the plane select and the row address are all zero. `reg_rdata` is 0, and `pix_vld` and `pix_grey` are 0.
- R2: A write strobe at offset 7 stores `reg_wdata` into the byte at the current column and row. Bit 7 of the last value written to offset 4 picks the plane (0 selects plane 1, 1 selects plane 2). Bits 4:0 of that value give the column (0–31), and bits 6:5 have no effect. Offset 5 holds the row (0–255).
- R3: A read strobe at offset 6 makes `reg_rdata` show the byte at the current address, one clock after the strobe. `reg_rdata` keeps its value across every other cycle, including reads at other offsets.
- R4: When mode bit 6 is 0, each data read or data write adds one to the column. The column wraps from 31 to 0, and the plane select and the row stay unchanged.
- R5: When mode bit 6 is 1, each data read or data write adds one to the row. The row wraps from 255 to 0, and the column and the plane select stay unchanged.
- R6: Within a stored byte, bit 7 is the leftmost pixel, at x = 8·column, and bit 0 is the pixel at x = 8·column + 7.
- R7: A `pix_req` with `pix_x` < 160 and `pix_y` < 152 gives `pix_vld` = 1 one clock later. `pix_grey` is then 2·p2 + p1, where p1 and p2 are the plane 1 and plane 2 pixels at ((`pix_x` + horizontal scroll) mod 256, (`pix_y` + vertical scroll) mod 256). The horizontal scroll is written at offset 2 and the vertical scroll at offset 3.
- R8: When mode bit 4 is 1, the grey value uses the swapped weighting 2·p1 + p2.
- R9: A cycle with no `pix_req`, or with a request outside the visible window, gives `pix_vld` = 0 and `pix_grey` = 0 one clock later.
- R10: A write at offset 0 changes no register and no stored pixel, and it does not step the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Byte returned by a data read |
| pix_req | input | 1 | Pixel fetch request |
| pix_x | input | 8 | Visible-window x coordinate |
| pix_y | input | 8 | Visible-window y coordinate |
| pix_vld | output | 1 | Pixel result valid |
| pix_grey | output | 2 | Grey level of the fetched pixel |

## Verification
The hardest cases to reach from the ports are the address wraps: the column passing from 31 to 0 without touching the plane bit, the row passing from 255 to 0, and scroll sums that wrap past 255. Each of these reads memory far from where the last write landed. The bench therefore first fills both planes completely with random bytes, using auto-stepped writes. Every later read and fetch then has a known expected value. Directed sequences then place the address at column 31 and row 255 and step across the edge. Scroll offsets near 255 push the pixel sum around. A long random mix of register, data and pixel operations follows.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

   // Register offsets within the block
   typedef enum logic [2:0] {
      OFS_NONE = 3'd0,
      OFS_MODE = 3'd1,
      OFS_XSCR = 3'd2,
      OFS_YSCR = 3'd3,
      OFS_XADR = 3'd4,
      OFS_YADR = 3'd5,
      OFS_DRD  = 3'd6,
      OFS_DWR  = 3'd7
   } reg_ofs_e;

   // Mode register bit positions
   localparam int MODE_SWAP_BIT  = 4;
   localparam int MODE_STEPY_BIT = 6;

   // Grey level from the two plane bits
   function automatic logic [1:0] grey_of(input logic p1, input logic p2, input logic swap);
      return swap ? {p1, p2} : {p2, p1};
   endfunction

endpackage

// File: rtl/lcdp_ctrl_regs.sv
module lcdp_ctrl_regs
   import lcdp_pkg::*;
#(
   parameter int COORD_W = 8,
   parameter int DATA_W  = 8,
   parameter int COL_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [2:0]         addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic               step_y,
   output logic               swap,
   output logic [COORD_W-1:0] x_scroll,
   output logic [COORD_W-1:0] y_scroll,
   output logic [COL_W-1:0]   x_col,
   output logic               x_plane,
   output logic [COORD_W-1:0] y_row,
   output logic               dwr,
   output logic               drd
);

   logic acc;

   assign dwr = wr && (addr == OFS_DWR);
   assign drd = rd && (addr == OFS_DRD);
   assign acc = dwr || drd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_y   <= 1'b0;
         swap     <= 1'b0;
         x_scroll <= '0;
         y_scroll <= '0;
         x_col    <= '0;
         x_plane  <= 1'b0;
         y_row    <= '0;
      end else begin
         if (wr) begin
            case (addr)
               OFS_MODE: begin
                  step_y <= wdata[MODE_STEPY_BIT];
                  swap   <= wdata[MODE_SWAP_BIT];
               end
               OFS_XSCR: x_scroll <= wdata[COORD_W-1:0];
               OFS_YSCR: y_scroll <= wdata[COORD_W-1:0];
               OFS_XADR: begin
                  x_col   <= wdata[COL_W-1:0];
                  x_plane <= wdata[DATA_W-1];
               end
               OFS_YADR: y_row <= wdata[COORD_W-1:0];
               default: ;
            endcase
         end
         if (acc) begin
            if (step_y) y_row <= y_row + 1'b1;
            else        x_col <= x_col + 1'b1;
         end
      end
   end

   // R3
   excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && rd));

   // R4
   xstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !step_y) |=> (x_col == COL_W'($past(x_col) + 1'b1)) && $stable(x_plane) && $stable(y_row));

   // R5
   ystep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && step_y) |=> (y_row == COORD_W'($past(y_row) + 1'b1)) && $stable(x_col) && $stable(x_plane));

   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !rd) |=> $stable(x_col) && $stable(y_row) && $stable(x_plane) && $stable(step_y)
                       && $stable(swap) && $stable(x_scroll) && $stable(y_scroll));

endmodule

// File: rtl/lcdp_plane_mem.sv
module lcdp_plane_mem #(
   parameter int COORD_W = 8,
   parameter int DATA_W  = 8,
   parameter int COL_W   = 5
) (
   input  logic               clk,
   input  logic               we,
   input  logic [COL_W-1:0]   col,
   input  logic [COORD_W-1:0] row,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rbyte,
   input  logic [COORD_W-1:0] pix_col,
   input  logic [COORD_W-1:0] pix_row,
   output logic               pix_bit
);

   localparam int DIM   = 1 << COORD_W;
   localparam int LOG_D = COORD_W - COL_W;

   // One entry per pixel row; bit index equals pixel x
   logic [DIM-1:0]    rows [DIM];
   logic [DATA_W-1:0] wrev;

   // Byte bit 7 maps to the leftmost pixel of the column
   for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      assign wrev[g] = wdata[DATA_W-1-g];
      assign rbyte[DATA_W-1-g] = rows[row][{col, LOG_D'(g)}];
   end

   always_ff @(posedge clk) begin
      if (we) begin
         for (int i = 0; i < DATA_W; i++) begin
            rows[row][{col, LOG_D'(i)}] <= wrev[LOG_D'(i)];
         end
      end
   end

   assign pix_bit = rows[pix_row][pix_col];

endmodule

// File: rtl/lcdp_pix_fetch.sv
module lcdp_pix_fetch
   import lcdp_pkg::*;
#(
   parameter int COORD_W = 8,
   parameter int VIS_W   = 160,
   parameter int VIS_H   = 152
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [COORD_W-1:0] vx,
   input  logic [COORD_W-1:0] vy,
   input  logic [COORD_W-1:0] xs,
   input  logic [COORD_W-1:0] ys,
   input  logic               swap,
   input  logic               bit1,
   input  logic               bit2,
   output logic [COORD_W-1:0] ax,
   output logic [COORD_W-1:0] ay,
   output logic               vld,
   output logic [1:0]         grey
);

   localparam logic [COORD_W:0] VW = (COORD_W+1)'(VIS_W);
   localparam logic [COORD_W:0] VH = (COORD_W+1)'(VIS_H);

   logic in_win;

   assign in_win = req && ({1'b0, vx} < VW) && ({1'b0, vy} < VH);
   assign ax     = vx + xs;
   assign ay     = vy + ys;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         grey <= 2'b00;
      end else begin
         vld  <= in_win;
         grey <= in_win ? grey_of(bit1, bit2, swap) : 2'b00;
      end
   end

   // R7
   fetch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ({1'b0, vx} < VW) && ({1'b0, vy} < VH)) |=> vld);

   // R9
   fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && ({1'b0, vx} < VW) && ({1'b0, vy} < VH)) |=> (!vld && grey == 2'b00));

endmodule

// File: rtl/lcdp_bitplane_port.sv
module lcdp_bitplane_port
   import lcdp_pkg::*;
#(
   parameter int COORD_W = 8,
   parameter int DATA_W  = 8,
   parameter int VIS_W   = 160,
   parameter int VIS_H   = 152,
   parameter int PLANES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [2:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               pix_req,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   output logic               pix_vld,
   output logic [1:0]         pix_grey
);

   localparam int DIM   = 1 << COORD_W;
   localparam int LOG_D = $clog2(DATA_W);
   localparam int COLS  = DIM / DATA_W;
   localparam int COL_W = $clog2(COLS);

   // Elaboration-time parameter checks
   if (COORD_W < 4 || COORD_W > DATA_W) begin : g_bad_coord
      $error("COORD_W must lie between 4 and DATA_W");
   end
   if ((1 << LOG_D) != DATA_W) begin : g_bad_data
      $error("DATA_W must be a power of two");
   end
   if (COL_W >= DATA_W) begin : g_bad_col
      $error("column field must leave room for the plane bit");
   end
   if (VIS_W > DIM || VIS_H > DIM || VIS_W < 1 || VIS_H < 1) begin : g_bad_vis
      $error("visible window must fit inside a plane");
   end
   if (PLANES != 2) begin : g_bad_planes
      $error("grey formation needs exactly two planes");
   end

   logic               step_y, swap, x_plane, dwr, drd;
   logic [COORD_W-1:0] x_scroll, y_scroll, y_row, ax, ay;
   logic [COL_W-1:0]   x_col;
   logic [DATA_W-1:0]  pl_byte [PLANES];
   logic [PLANES-1:0]  pl_bit;

   lcdp_ctrl_regs #(
      .COORD_W(COORD_W), .DATA_W(DATA_W), .COL_W(COL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .step_y(step_y), .swap(swap), .x_scroll(x_scroll),
      .y_scroll(y_scroll), .x_col(x_col), .x_plane(x_plane), .y_row(y_row),
      .dwr(dwr), .drd(drd)
   );

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      lcdp_plane_mem #(
         .COORD_W(COORD_W), .DATA_W(DATA_W), .COL_W(COL_W)
      ) u_mem (
         .clk(clk), .we(dwr && (x_plane == p[0])), .col(x_col), .row(y_row),
         .wdata(reg_wdata), .rbyte(pl_byte[p]), .pix_col(ax), .pix_row(ay),
         .pix_bit(pl_bit[p])
      );
   end

   lcdp_pix_fetch #(
      .COORD_W(COORD_W), .VIS_W(VIS_W), .VIS_H(VIS_H)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .req(pix_req), .vx(pix_x), .vy(pix_y),
      .xs(x_scroll), .ys(y_scroll), .swap(swap), .bit1(pl_bit[0]),
      .bit2(pl_bit[1]), .ax(ax), .ay(ay), .vld(pix_vld), .grey(pix_grey)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)   reg_rdata <= '0;
      else if (drd) reg_rdata <= x_plane ? pl_byte[1] : pl_byte[0];
   end

   // R3
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == OFS_DRD) |=> $stable(reg_rdata));

endmodule

// File: tb/lcdp_bitplane_port_tb.sv
module lcdp_bitplane_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0, pix_req = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, pix_x = '0, pix_y = '0;
   logic [7:0] reg_rdata;
   logic       pix_vld;
   logic [1:0] pix_grey;

   always #5 clk = ~clk;

   lcdp_bitplane_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y),
      .pix_vld(pix_vld), .pix_grey(pix_grey)
   );

   // Reference model
   logic [255:0] m [2][256];
   logic       m_stepy, m_swap, m_pl;
   logic [7:0] m_xs, m_ys, m_row;
   logic [4:0] m_col;
   int nvec = 0, nfail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input logic p, input logic [7:0] r, input logic [4:0] c);
      logic [7:0] b;
      for (int i = 0; i < 8; i++) b[7-i] = m[p][r][{c, 3'(i)}];
      return b;
   endfunction

   function automatic logic [1:0] mpix(input logic [7:0] vx, input logic [7:0] vy);
      logic [7:0] ax, ay;
      logic p1, p2;
      ax = vx + m_xs;
      ay = vy + m_ys;
      p1 = m[0][ay][ax];
      p2 = m[1][ay][ax];
      return m_swap ? {p1, p2} : {p2, p1};
   endfunction

   task automatic mstep();
      if (m_stepy) m_row = m_row + 8'd1;
      else         m_col = m_col + 5'd1;
   endtask

   task automatic mreset();
      m_stepy = 0; m_swap = 0; m_pl = 0; m_xs = 0; m_ys = 0; m_row = 0; m_col = 0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      case (a)
         3'd1: begin m_stepy = d[6]; m_swap = d[4]; end
         3'd2: m_xs = d;
         3'd3: m_ys = d;
         3'd4: begin m_col = d[4:0]; m_pl = d[7]; end
         3'd5: m_row = d;
         3'd7: begin
            for (int i = 0; i < 8; i++) m[m_pl][m_row][{m_col, 3'(i)}] = d[7-i];
            mstep();
         end
         default: ;
      endcase
   endtask

   task automatic rd_check(input string req);
      logic [7:0] exp;
      exp = mbyte(m_pl, m_row, m_col);
      reg_rd = 1'b1; reg_addr = 3'd6;
      @(negedge clk);
      reg_rd = 1'b0;
      chk(reg_rdata === exp, req, reg_rdata, exp);
      mstep();
   endtask

   task automatic rd_other(input logic [2:0] a);
      logic [7:0] keep;
      keep = reg_rdata;
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      chk(reg_rdata === keep, "R3 hold on other read", reg_rdata, keep);
   endtask

   task automatic pix_check(input logic [7:0] vx, input logic [7:0] vy, input bit req, input string tag);
      bit inwin;
      logic [1:0] exp;
      inwin = req && vx < 8'd160 && vy < 8'd152;
      exp = inwin ? mpix(vx, vy) : 2'b00;
      pix_req = req; pix_x = vx; pix_y = vy;
      @(negedge clk);
      pix_req = 1'b0;
      chk(pix_vld === inwin, tag, pix_vld, inwin);
      chk(pix_grey === exp, tag, pix_grey, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mreset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1f2e_3d4c));
      mreset();
      @(negedge clk);
      do_reset();
      // R1: reset state at the ports
      chk(reg_rdata === 8'h00, "R1 rdata", reg_rdata, 0);
      chk(pix_vld === 1'b0, "R1 pix_vld", pix_vld, 0);
      chk(pix_grey === 2'b00, "R1 pix_grey", pix_grey, 0);

      // Fill both planes by auto-stepped writes (R2, R4 wrap after column 31)
      for (int p = 0; p < 2; p++) begin
         for (int y = 0; y < 256; y++) begin
            wr_reg(3'd4, {p[0], 7'd0});
            wr_reg(3'd5, 8'(y));
            for (int c = 0; c < 32; c++) wr_reg(3'd7, 8'($urandom));
         end
      end

      // R1: registers reset again, memory kept; read at plane 1 row 0 column 0
      do_reset();
      rd_check("R1 address after reset");
      pix_check(8'd3, 8'd4, 1'b1, "R1 scroll/swap after reset");

      // R4: column wrap keeps plane bit
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd4, 8'h9F);
      wr_reg(3'd5, 8'd7);
      rd_check("R4 column 31");
      rd_check("R4 wrap to column 0 plane 2");
      // R2: bits 6:5 of X have no effect
      wr_reg(3'd4, 8'h63);
      wr_reg(3'd7, 8'hA5);
      wr_reg(3'd4, 8'h03);
      rd_check("R2 ignored bits 6:5");

      // R5: row wrap keeps column
      wr_reg(3'd1, 8'h40);
      wr_reg(3'd4, 8'h85);
      wr_reg(3'd5, 8'hFF);
      rd_check("R5 row 255");
      rd_check("R5 wrap to row 0");
      rd_check("R5 row 1 same column");

      // R3: other offsets leave rdata alone
      rd_other(3'd2);
      rd_other(3'd5);

      // R10: write at offset 0 is ignored
      wr_reg(3'd0, 8'hFF);
      rd_check("R10 offset 0 write ignored");

      // R6: bit order within a byte
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd2, 8'h00);
      wr_reg(3'd3, 8'h00);
      wr_reg(3'd4, 8'h02); wr_reg(3'd5, 8'd9); wr_reg(3'd7, 8'h80);
      wr_reg(3'd4, 8'h82); wr_reg(3'd5, 8'd9); wr_reg(3'd7, 8'h01);
      pix_check(8'd16, 8'd9, 1'b1, "R6 bit 7 leftmost");
      chk(pix_grey === 2'd1, "R6 literal x16", pix_grey, 1);
      pix_check(8'd23, 8'd9, 1'b1, "R6 bit 0 rightmost");
      chk(pix_grey === 2'd2, "R6 literal x23", pix_grey, 2);

      // R8: swapped weighting
      wr_reg(3'd1, 8'h10);
      pix_check(8'd23, 8'd9, 1'b1, "R8 swap");
      chk(pix_grey === 2'd1, "R8 literal x23", pix_grey, 1);

      // R7: scroll wrap on both axes
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd2, 8'd250);
      wr_reg(3'd3, 8'd200);
      pix_check(8'd22, 8'd65, 1'b1, "R7 scroll wrap");
      chk(pix_grey === 2'd1, "R7 literal wrap", pix_grey, 1);
      pix_check(8'd29, 8'd65, 1'b1, "R7 scroll wrap right");

      // R9: outside window and idle
      pix_check(8'd160, 8'd0, 1'b1, "R9 x edge");
      pix_check(8'd0, 8'd152, 1'b1, "R9 y edge");
      pix_check(8'd159, 8'd151, 1'b1, "R7 last visible pixel");
      pix_check(8'd10, 8'd10, 1'b0, "R9 no request");

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         int op;
         op = int'($urandom % 10);
         case (op)
            0: wr_reg(3'd1, 8'($urandom));
            1: wr_reg(($urandom % 2) ? 3'd2 : 3'd3, 8'($urandom));
            2: wr_reg(3'd4, 8'($urandom));
            3: wr_reg(3'd5, 8'($urandom));
            4, 5: wr_reg(3'd7, 8'($urandom));
            6, 7: rd_check("R3/R4/R5 random read");
            default: pix_check(8'($urandom % 176), 8'($urandom % 168),
                               ($urandom % 8) != 0, "R7/R8/R9 random fetch");
         endcase
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule